// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. For each operation it takes an operation code, a register operand A (accumulator or index register), a memory operand M and the incoming carry. It returns an 8-bit result, new values for the negative (N), overflow (V), zero (Z) and carry (C) flags, and one enable per flag. The enable tells the owner of the status register which flags the operation changes. The block does not write registers or memory, and it has no decimal mode.

Operands enter through a valid/ready port and results leave through one output stage with valid/ready. A transfer happens on a rising clock edge when valid and ready are both high. The input port is ready when the output stage is empty or is being drained in the same cycle, so back-pressure from the consumer reaches the producer without loss. A stalled result stays stable until the consumer accepts it. Shift, rotate, increment and decrement act on M; when the accumulator is the target, the caller places A on the M input.

Top module: `alu8_unit`

## Requirements
- R1: An input accepted on a clock edge (in_valid and in_ready high) appears on the outputs with out_valid high after exactly that one edge. in_ready is high whenever out_valid is low or out_ready is high.
- R2: Add (code 0) gives R = A + M + carry-in, and C is bit 8 of the 9-bit sum. Enables are N, V, Z and C.
- R3: For add and subtract, V is bit 7 of (A xor R) and not (A xor M'), where M' is the addend actually used (M for add, M xor 0xFF for subtract).
- R4: Subtract (code 1) equals add applied to M xor 0xFF with the incoming carry, so C=1 means no borrow. Enables are N, V, Z and C.
- R5: Compare (code 2) gives R = A - M, ignores carry-in and sets C when A >= M unsigned. Enables are N, Z and C; V is not enabled.
- R6: AND (code 3), OR (code 4) and XOR (code 5) enable only N and Z. N is R bit 7 and Z is (R == 0).
- R7: Bit test (code 6) returns A unchanged as the result. Z is ((A and M) == 0), V is M bit 6 and N is M bit 7. Enables are N, V and Z.
- R8: Shift left (code 7) gives R = M << 1. Rotate left (code 9) gives R = {M[6:0], carry-in}. Both put old M bit 7 into C and enable N, Z and C.
- R9: Shift right (code 8) gives R = M >> 1, puts M bit 0 into C and forces N to 0. Rotate right (code 10) gives R = {carry-in, M[7:1]} and puts M bit 0 into C. Both enable N, Z and C.
- R10: Increment (code 11) and decrement (code 12) give M + 1 and M - 1 modulo 256 and enable only N and Z.
- R11: out_upd holds the enables as {N, V, Z, C} in bits 3..0, and a flag output whose enable is low reads 0. Codes 13 to 15 pass A through with no flag enabled.
- R12: While out_valid is high and out_ready is low, the result, the flags and out_upd hold stable and no new input is accepted.
- R13: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block can take an operand set |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | Register operand A |
| in_m | input | 8 | Memory operand M |
| in_c | input | 1 | Incoming carry |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 8 | Result byte |
| out_n | output | 1 | Negative flag value |
| out_v | output | 1 | Overflow flag value |
| out_z | output | 1 | Zero flag value |
| out_c | output | 1 | Carry flag value |
| out_upd | output | 4 | Flag enables {N,V,Z,C} |

## Verification
Each result, its flags and its enables are due one edge after the operand set is accepted. The bench drives operands at a falling edge, lets one rising edge take them and compares every output at the next falling edge. In the stall tests the outputs are checked at each falling edge while out_ready is low, so that each check confirms the held result and the blocked input. After out_ready rises, the bench checks that the waiting operand's result appears one edge later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  // flag vector order: N, V, Z, C in bits 3..0
  localparam int unsigned FL_N = 3;
  localparam int unsigned FL_V = 2;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_C = 0;

  typedef struct packed {
    logic       n;
    logic       v;
    logic       z;
    logic       c;
  } flags_t;
endpackage

// File: rtl/alu8_arith.sv
// Carry-chain unit shared by add, subtract, compare, increment, decrement.
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    m,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic            ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         ci;
  logic [W:0]   sum;

  always_comb begin
    lhs = a;
    rhs = m;
    ci  = cin;
    unique case (op)
      OP_SUB: begin rhs = ~m; ci = cin; end
      OP_CMP: begin rhs = ~m; ci = 1'b1; end
      OP_INC: begin lhs = m; rhs = '0; ci = 1'b1; end
      OP_DEC: begin lhs = m; rhs = '1; ci = 1'b0; end
      default: begin lhs = a; rhs = m; ci = cin; end
    endcase
  end

  assign sum  = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, ci};
  assign res  = sum[W-1:0];
  assign cout = sum[W];
  // signed overflow: operands agree in sign, result disagrees
  assign ovf  = (lhs[MSB] ^ res[MSB]) & ~(lhs[MSB] ^ rhs[MSB]);
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, OR, XOR and the bit-test probe.
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    m,
  output logic [W-1:0]    res,
  output logic            probe_zero
);
  logic [W-1:0] both;

  assign both       = a & m;
  assign probe_zero = (both == '0);

  always_comb begin
    unique case (op)
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_BIT:  res = a;
      default: res = both;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
// Single-position shifter: shift/rotate in either direction through carry.
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    m,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);
  localparam int unsigned MSB = W - 1;

  logic go_left;
  logic fill;

  always_comb begin
    go_left = (op == OP_SHL) || (op == OP_ROL);
    fill    = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
  end

  always_comb begin
    if (go_left) begin
      res  = {m[MSB-1:0], fill};
      cout = m[MSB];
    end else begin
      res  = {fill, m[MSB:1]};
      cout = m[0];
    end
  end
endmodule

// File: rtl/alu8_unit.sv
// ALU with status flags behind a one-deep valid/ready output stage.
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_m,
  input  logic            in_c,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_res,
  output logic            out_n,
  output logic            out_v,
  output logic            out_z,
  output logic            out_c,
  output logic [3:0]      out_upd
);
  localparam int unsigned MSB  = W - 1;
  localparam int unsigned NFLG = 4;

  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, ar_v, sh_c, lg_pz;

  alu8_arith #(.W(W)) u_arith (
    .op(in_op), .a(in_a), .m(in_m), .cin(in_c),
    .res(ar_res), .cout(ar_c), .ovf(ar_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(in_op), .a(in_a), .m(in_m),
    .res(lg_res), .probe_zero(lg_pz)
  );

  alu8_shift #(.W(W)) u_shift (
    .op(in_op), .m(in_m), .cin(in_c),
    .res(sh_res), .cout(sh_c)
  );

  logic [W-1:0]    nx_res;
  logic [NFLG-1:0] nx_flg;
  logic [NFLG-1:0] nx_upd;
  logic [NFLG-1:0] raw_flg;

  always_comb begin
    nx_res  = in_a;
    raw_flg = '0;
    nx_upd  = '0;
    unique case (in_op)
      OP_ADD, OP_SUB: begin
        nx_res          = ar_res;
        raw_flg[FL_C]   = ar_c;
        raw_flg[FL_V]   = ar_v;
        nx_upd          = 4'b1111;
      end
      OP_CMP: begin
        nx_res          = ar_res;
        raw_flg[FL_C]   = ar_c;
        nx_upd          = 4'b1011;
      end
      OP_INC, OP_DEC: begin
        nx_res          = ar_res;
        nx_upd          = 4'b1010;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nx_res          = lg_res;
        nx_upd          = 4'b1010;
      end
      OP_BIT: begin
        nx_res          = lg_res;
        nx_upd          = 4'b1110;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nx_res          = sh_res;
        raw_flg[FL_C]   = sh_c;
        nx_upd          = 4'b1011;
      end
      default: begin
        nx_res          = in_a;
        nx_upd          = '0;
      end
    endcase

    if (in_op == OP_BIT) begin
      raw_flg[FL_Z] = lg_pz;
      raw_flg[FL_V] = in_m[MSB-1];
      raw_flg[FL_N] = in_m[MSB];
    end else begin
      raw_flg[FL_Z] = (nx_res == '0);
      raw_flg[FL_N] = nx_res[MSB];
    end
  end

  // a flag not written by the operation reads 0
  genvar gi;
  generate
    for (gi = 0; gi < NFLG; gi++) begin : g_mask
      assign nx_flg[gi] = raw_flg[gi] & nx_upd[gi];
    end
  endgenerate

  logic            vld_q;
  logic [W-1:0]    res_q;
  logic [NFLG-1:0] flg_q;
  logic [NFLG-1:0] upd_q;
  logic            take;

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
      upd_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        res_q <= nx_res;
        flg_q <= nx_flg;
        upd_q <= nx_upd;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_res   = res_q;
  assign out_n     = flg_q[FL_N];
  assign out_v     = flg_q[FL_V];
  assign out_z     = flg_q[FL_Z];
  assign out_c     = flg_q[FL_C];
  assign out_upd   = upd_q;
endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic [W-1:0]    in_a,
  input logic [W-1:0]    in_m,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_res,
  input logic            out_n,
  input logic            out_v,
  input logic            out_z,
  input logic [3:0]      out_upd
);
  logic acc;
  assign acc = in_valid & in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)
                                   && $stable(out_upd) && $stable(out_z)));

  p_bit_keeps_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_BIT) |=> (out_res == $past(in_a) && out_v == $past(in_m[W-2])));

  p_logic_no_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR))
      |=> (out_upd == 4'b1010 && !out_v));

  p_shr_n_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_SHR) |=> (!out_n && out_upd[0]));

  p_inc_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_INC && in_m == '1) |=> (out_res == '0 && out_z));
endmodule

bind alu8_unit alu8_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_m(in_m), .out_valid(out_valid),
  .out_ready(out_ready), .out_res(out_res), .out_n(out_n), .out_v(out_v),
  .out_z(out_z), .out_upd(out_upd)
);

// File: tb/alu8_unit_tb.sv
module alu8_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_m = '0;
  logic       in_c = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic       out_n, out_v, out_z, out_c;
  logic [3:0] out_upd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_m(in_m), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_n(out_n), .out_v(out_v), .out_z(out_z), .out_c(out_c),
    .out_upd(out_upd)
  );

  // {op, a, m, cin, result, flags NVZC, enables NVZC}
  localparam logic [36:0] VEC [0:NVEC-1] = '{
    {4'd0,  8'h50, 8'h50, 1'b0, 8'hA0, 4'b1100, 4'b1111},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b0011, 4'b1111},
    {4'd0,  8'h10, 8'h20, 1'b1, 8'h31, 4'b0000, 4'b1111},
    {4'd1,  8'h50, 8'hB0, 1'b1, 8'hA0, 4'b1100, 4'b1111},
    {4'd1,  8'h05, 8'h03, 1'b1, 8'h02, 4'b0001, 4'b1111},
    {4'd1,  8'h03, 8'h05, 1'b0, 8'hFD, 4'b1000, 4'b1111},
    {4'd2,  8'h40, 8'h40, 1'b0, 8'h00, 4'b0011, 4'b1011},
    {4'd2,  8'h10, 8'h20, 1'b1, 8'hF0, 4'b1000, 4'b1011},
    {4'd3,  8'hF0, 8'h0F, 1'b1, 8'h00, 4'b0010, 4'b1010},
    {4'd4,  8'h80, 8'h01, 1'b1, 8'h81, 4'b1000, 4'b1010},
    {4'd5,  8'hFF, 8'hFF, 1'b0, 8'h00, 4'b0010, 4'b1010},
    {4'd6,  8'h0F, 8'hC0, 1'b0, 8'h0F, 4'b1110, 4'b1110},
    {4'd6,  8'h41, 8'h01, 1'b1, 8'h41, 4'b0000, 4'b1110},
    {4'd7,  8'h33, 8'h81, 1'b1, 8'h02, 4'b0001, 4'b1011},
    {4'd8,  8'h33, 8'h01, 1'b1, 8'h00, 4'b0011, 4'b1011},
    {4'd8,  8'h33, 8'hFE, 1'b0, 8'h7F, 4'b0000, 4'b1011},
    {4'd9,  8'h33, 8'h80, 1'b1, 8'h01, 4'b0001, 4'b1011},
    {4'd10, 8'h33, 8'h01, 1'b1, 8'h80, 4'b1001, 4'b1011},
    {4'd10, 8'h33, 8'h02, 1'b0, 8'h01, 4'b0000, 4'b1011},
    {4'd11, 8'h33, 8'hFF, 1'b1, 8'h00, 4'b0010, 4'b1010},
    {4'd12, 8'h33, 8'h00, 1'b0, 8'hFF, 4'b1000, 4'b1010},
    {4'd12, 8'h33, 8'h80, 1'b1, 8'h7F, 4'b0000, 4'b1010},
    {4'd13, 8'h5A, 8'hFF, 1'b1, 8'h5A, 4'b0000, 4'b0000}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0:          return "R2/R3";
      4'd1:          return "R4/R3";
      4'd2:          return "R5";
      4'd3, 4'd4, 4'd5: return "R6";
      4'd6:          return "R7";
      4'd7, 4'd9:    return "R8";
      4'd8, 4'd10:   return "R9";
      4'd11, 4'd12:  return "R10";
      default:       return "R11";
    endcase
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] er,
                           input logic [3:0] ef, input logic [3:0] eu);
    logic [16:0] act, exp;
    act = {out_valid, out_res, out_n, out_v, out_z, out_c, out_upd};
    exp = {1'b1, er, ef, eu};
    check(req, act == exp, "valid/res/flags/upd", {15'b0, act}, {15'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    check("R13", out_valid == 1'b0, "out_valid", {31'b0, out_valid}, 32'd0);
    check("R13", in_ready == 1'b1, "in_ready", {31'b0, in_ready}, 32'd1);

    // table walk; R1 one-edge latency, R11 masked flags
    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      in_op = v[36:33]; in_a = v[32:25]; in_m = v[24:17]; in_c = v[16];
      in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(req_of(v[36:33]), v[15:8], v[7:4], v[3:0]);
    end

    // R1: with nothing sent and consumer ready, output drains
    @(negedge clk);
    check("R1", out_valid == 1'b0, "drain out_valid", {31'b0, out_valid}, 32'd0);

    // R12: back-pressure hold
    in_op = 4'd0; in_a = 8'h01; in_m = 8'h01; in_c = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_a = 8'h03; in_m = 8'h03;
    check_out("R12", 8'h02, 4'b0000, 4'b1111);
    check("R12", in_ready == 1'b0, "in_ready stalled", {31'b0, in_ready}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_out("R12", 8'h02, 4'b0000, 4'b1111);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R1", 8'h06, 4'b0000, 4'b1111);
    @(posedge clk);
    @(negedge clk);
    check("R1", out_valid == 1'b0, "after drain", {31'b0, out_valid}, 32'd0);

    // R11: code 15 pass-through, no flags even with negative zero-ish data
    in_op = 4'd15; in_a = 8'h80; in_m = 8'h00; in_c = 1'b1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R11", 8'h80, 4'b0000, 4'b0000);

    // R13: reset in mid-stream clears the output stage
    out_ready = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R13", out_valid == 1'b0, "out_valid after reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule